// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers seven interrupt sources for a small processor core and picks one. It then presents the address of that source's vector word pair. The sources are the power-on reset request, a non-maskable timer event, a coprocessor-finished event, a converter-finished event, a periodic timer event, a group of general-purpose input pins, and one external request pin. Every source has a sticky pending flag. The core takes a granted vector and returns a one-cycle acknowledge, which clears only the flag of the source it was given.

The group pins and the external pin are asynchronous. They pass through a synchronizer chain before edge detection. A group pin raises a request on its high-to-low transition, and only when its bit in an enable register is written to 0. Every enable bit comes out of reset at 1, which means disabled. The external pin raises a request on its low-to-high transition, and only when the pin is configured for interrupt use. A global mask input holds back the five maskable sources but never the reset request or the non-maskable event.

The block also runs the two low-power waits. In standby the core is held, and any pending source other than reset releases it. In sleep only an external-pin request releases it.

The controller is one state machine with four states:

| State | Meaning |
|-------|---------|
| IDLE | Arbitrating. |
| GRANT | A vector is presented and held. |
| STBY | Standby wait. |
| SLEEP | Sleep wait. |

Its transitions are:

- **IDLE to GRANT** when any eligible request exists. The winner is latched.
- **IDLE to SLEEP** on a sleep request when nothing is eligible.
- **IDLE to STBY** on a standby request when nothing is eligible and no sleep request is present.
- **GRANT to IDLE** on acknowledge.
- **STBY to IDLE** when any non-reset source is pending. This transition pulses the wake output.
- **SLEEP to IDLE** when the external source is pending. This transition also pulses the wake output.

Top module: `irq_vec_ctrl`

## Requirements
- R1: While reset is asserted, vec_valid and cpu_hold are 0. The first vector granted after reset release is the reset vector 0xFFFC.
- R2: When several sources are eligible, they are granted one after another. The order from first to last is reset, non-maskable, coprocessor, converter, timer, pin group, external.
- R3: The vector word addresses are as follows. Coprocessor is 0xFFF0, converter 0xFFF2, timer 0xFFF6, pin group 0xFFF8, non-maskable 0xFFFA, reset 0xFFFC and external 0xFFFE. 0xFFF4 is never issued.
- R4: A high-to-low transition on group pin i sets the pin-group request only if bit i of the enable register is 0. The register is loaded from pin_en_n_wdata when pin_en_n_we is 1, and all of its bits reset to 1. Low-to-high transitions and transitions on disabled pins produce no vector.
- R5: A low-to-high transition on ext_pin sets the external request only while ext_irq_mode is 1. Falling transitions, and any transition with ext_irq_mode at 0, produce no vector.
- R6: While irq_mask is 1, coprocessor, converter, timer, pin-group and external requests are not granted but stay pending, and they are granted after irq_mask returns to 0. Reset and non-maskable requests are granted regardless of irq_mask.
- R7: While vec_valid is 1 without ack, vec_addr and vec_src hold, even if a higher-priority request arrives. The cycle after ack, vec_valid is 0. An acknowledge clears only the granted source's pending flag.
- R8: A standby request taken in IDLE sets cpu_hold. Any pending non-reset source then pulses wake for one cycle and releases cpu_hold on the next edge, whatever the state of irq_mask.
- R9: In sleep, cpu_hold stays 1 and no vector is issued while non-external sources become pending. An external request pulses wake and releases cpu_hold, after which the waiting sources are granted in priority order.
- R10: Standby and sleep requests are acted on only in IDLE with no eligible request. A sleep request wins over a simultaneous standby request, and a request seen in GRANT is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_evt | input | 1 | Non-maskable event, single-cycle synchronous pulse |
| cop_evt | input | 1 | Coprocessor-finished event pulse |
| adc_evt | input | 1 | Converter-finished event pulse |
| tmr_evt | input | 1 | Timer event pulse |
| pin_in | input | NPIN | Asynchronous group pins, falling-edge sensitive |
| pin_en_n_we | input | 1 | Write strobe of the active-low pin enable register |
| pin_en_n_wdata | input | NPIN | Write data of the pin enable register |
| ext_pin | input | 1 | Asynchronous external request pin, rising-edge sensitive |
| ext_irq_mode | input | 1 | 1 selects interrupt use of ext_pin |
| irq_mask | input | 1 | Global mask of the maskable sources |
| ack | input | 1 | Acknowledge of the presented vector |
| stby_req | input | 1 | Standby entry request pulse |
| sleep_req | input | 1 | Sleep entry request pulse |
| vec_valid | output | 1 | A vector is presented |
| vec_addr | output | AW | Vector word address |
| vec_src | output | 3 | Granted source code, 0 reset up to 6 external, in priority order |
| cpu_hold | output | 1 | Core held in standby or sleep |
| wake | output | 1 | One-cycle release pulse of a low-power wait |

## Verification
The bench builds the block with NPIN=8, SYNC_STAGES=2, AW=16 and a vector base of 0xFFF0, so every issued address can be compared with the fixed vector words above. The two-stage synchronizer keeps the pin-to-grant latency at a few cycles, which lets short polling windows observe both the presence and the absence of a grant after each pin transition. With eight pins, enabling a single middle bit shows that only that pin is accepted while its neighbours and the default-disabled register are ignored.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int NSRC = 7;

    // Source codes in priority order: lower code wins.
    typedef enum logic [2:0] {
        SRC_RST = 3'd0,
        SRC_NMI = 3'd1,
        SRC_COP = 3'd2,
        SRC_ADC = 3'd3,
        SRC_TMR = 3'd4,
        SRC_PIN = 3'd5,
        SRC_EXT = 3'd6
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_STBY  = 2'd2,
        ST_SLEEP = 2'd3
    } state_e;

    // Sources held back by the global mask.
    localparam logic [NSRC-1:0] MASKABLE = 7'b111_1100;

    // Word-pair slot above the vector base for each source.
    function automatic logic [2:0] vec_slot(input src_e s);
        logic [2:0] r;
        unique case (s)
            SRC_COP: r = 3'd0;
            SRC_ADC: r = 3'd1;
            SRC_TMR: r = 3'd3;
            SRC_PIN: r = 3'd4;
            SRC_NMI: r = 3'd5;
            SRC_RST: r = 3'd6;
            SRC_EXT: r = 3'd7;
            default: r = 3'd6;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ivc_sync.sv
module ivc_sync #(
    parameter int   W       = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= {W{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ivc_edge.sv
module ivc_edge #(
    parameter int   W       = 1,
    parameter logic FALL    = 1'b0,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= {W{RST_VAL}};
        else        prev <= lvl;
    end

    generate
        if (FALL) begin : g_fall
            assign hit = prev & ~lvl;
        end else begin : g_rise
            assign hit = ~prev & lvl;
        end
    endgenerate
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio
    import ivc_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] req,
    output logic         any,
    output src_e         win
);
    assign any = |req;

    always_comb begin
        win = SRC_RST;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) win = src_e'(3'(i));
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import ivc_pkg::*;
#(
    parameter int             NPIN        = 8,
    parameter int             SYNC_STAGES = 2,
    parameter int             AW          = 16,
    parameter logic [AW-1:0]  VEC_BASE    = 16'hFFF0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            nmi_evt,
    input  logic            cop_evt,
    input  logic            adc_evt,
    input  logic            tmr_evt,
    input  logic [NPIN-1:0] pin_in,
    input  logic            pin_en_n_we,
    input  logic [NPIN-1:0] pin_en_n_wdata,
    input  logic            ext_pin,
    input  logic            ext_irq_mode,
    input  logic            irq_mask,
    input  logic            ack,
    input  logic            stby_req,
    input  logic            sleep_req,
    output logic            vec_valid,
    output logic [AW-1:0]   vec_addr,
    output logic [2:0]      vec_src,
    output logic            cpu_hold,
    output logic            wake
);
    localparam logic [NSRC-1:0] NONRESET = ~(NSRC'(1) << SRC_RST);

    // ---------------- pin front end ----------------
    logic [NPIN-1:0] pin_s;
    logic [NPIN-1:0] pin_fall;
    logic [0:0]      ext_s;
    logic [0:0]      ext_rise;
    logic [NPIN-1:0] pin_en_n;

    ivc_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
    );
    ivc_edge #(.W(NPIN), .FALL(1'b1), .RST_VAL(1'b1)) u_pin_edge (
        .clk(clk), .rst_n(rst_n), .lvl(pin_s), .hit(pin_fall)
    );
    ivc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_pin), .q(ext_s)
    );
    ivc_edge #(.W(1), .FALL(1'b0), .RST_VAL(1'b0)) u_ext_edge (
        .clk(clk), .rst_n(rst_n), .lvl(ext_s), .hit(ext_rise)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           pin_en_n <= '1;
        else if (pin_en_n_we) pin_en_n <= pin_en_n_wdata;
    end

    // ---------------- pending flags ----------------
    state_e          state, state_nxt;
    src_e            cur_src;
    logic [NSRC-1:0] pend, set_v, clr_v, elig;
    logic            any_elig;
    src_e            win;

    always_comb begin
        set_v          = '0;
        set_v[SRC_NMI] = nmi_evt;
        set_v[SRC_COP] = cop_evt;
        set_v[SRC_ADC] = adc_evt;
        set_v[SRC_TMR] = tmr_evt;
        set_v[SRC_PIN] = |(pin_fall & ~pin_en_n);
        set_v[SRC_EXT] = ext_rise[0] & ext_irq_mode;
    end

    assign clr_v = (state == ST_GRANT && ack) ? (NSRC'(1) << cur_src) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= NSRC'(1) << SRC_RST;
        else        pend <= (pend & ~clr_v) | set_v;
    end

    assign elig = pend & ~(irq_mask ? MASKABLE : '0);

    ivc_prio #(.N(NSRC)) u_prio (.req(elig), .any(any_elig), .win(win));

    // ---------------- state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_src <= SRC_RST;
        end else begin
            state <= state_nxt;
            if (state == ST_IDLE && any_elig) cur_src <= win;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (any_elig)       state_nxt = ST_GRANT;
                else if (sleep_req) state_nxt = ST_SLEEP;
                else if (stby_req)  state_nxt = ST_STBY;
            end
            ST_GRANT: if (ack)                     state_nxt = ST_IDLE;
            ST_STBY:  if (|(pend & NONRESET))      state_nxt = ST_IDLE;
            ST_SLEEP: if (pend[SRC_EXT])           state_nxt = ST_IDLE;
            default:                               state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        vec_valid = (state == ST_GRANT);
        vec_src   = cur_src;
        vec_addr  = VEC_BASE + (AW'(vec_slot(cur_src)) << 1);
        cpu_hold  = (state == ST_STBY) || (state == ST_SLEEP);
        wake      = ((state == ST_STBY)  && |(pend & NONRESET)) ||
                    ((state == ST_SLEEP) && pend[SRC_EXT]);
    end
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
    import ivc_pkg::*;
#(
    parameter int            AW       = 16,
    parameter logic [AW-1:0] VEC_BASE = 16'hFFF0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_mask,
    input logic          ack,
    input logic          vec_valid,
    input logic [AW-1:0] vec_addr,
    input logic [2:0]    vec_src,
    input logic          cpu_hold,
    input logic          wake
);
    // R7: presented vector holds until acknowledged
    p_vec_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !ack) |=> (vec_valid && $stable(vec_addr) && $stable(vec_src)));

    // R7: acknowledge withdraws the vector on the next cycle
    p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && ack) |=> !vec_valid);

    // R3: issued addresses are word-pair aligned and never the unused slot
    p_vec_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_addr[0] == 1'b0 && vec_addr != VEC_BASE + AW'(4)));

    // R6: with the mask set, only reset or non-maskable grants start
    p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vec_valid) && $past(irq_mask)) |-> (vec_src <= 3'(SRC_NMI)));

    // R8: a wake pulse releases the hold on the next edge
    p_wake_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !cpu_hold);

    // R9: the hold is only released after a wake pulse
    p_hold_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_hold) |-> $past(wake));
endmodule

bind irq_vec_ctrl ivc_checker #(.AW(AW), .VEC_BASE(VEC_BASE)) u_ivc_checker (
    .clk(clk), .rst_n(rst_n), .irq_mask(irq_mask), .ack(ack),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .vec_src(vec_src),
    .cpu_hold(cpu_hold), .wake(wake)
);

// File: tb/irq_vec_ctrl_tb_top.sv
module irq_vec_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPIN = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            nmi_evt = 0, cop_evt = 0, adc_evt = 0, tmr_evt = 0;
    logic [NPIN-1:0] pin_in = '1;
    logic            pin_en_n_we = 0;
    logic [NPIN-1:0] pin_en_n_wdata = '1;
    logic            ext_pin = 0, ext_irq_mode = 0, irq_mask = 0;
    logic            ack = 0, stby_req = 0, sleep_req = 0;
    logic            vec_valid;
    logic [15:0]     vec_addr;
    logic [2:0]      vec_src;
    logic            cpu_hold, wake;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vec_ctrl #(.NPIN(NPIN), .SYNC_STAGES(2), .AW(16), .VEC_BASE(16'hFFF0)) dut_i (
        .clk(clk), .rst_n(rst_n), .nmi_evt(nmi_evt), .cop_evt(cop_evt),
        .adc_evt(adc_evt), .tmr_evt(tmr_evt), .pin_in(pin_in),
        .pin_en_n_we(pin_en_n_we), .pin_en_n_wdata(pin_en_n_wdata),
        .ext_pin(ext_pin), .ext_irq_mode(ext_irq_mode), .irq_mask(irq_mask),
        .ack(ack), .stby_req(stby_req), .sleep_req(sleep_req),
        .vec_valid(vec_valid), .vec_addr(vec_addr), .vec_src(vec_src),
        .cpu_hold(cpu_hold), .wake(wake)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // wait for a vector, compare, then acknowledge it
    task automatic expect_vec(input logic [15:0] exp, input string tag);
        bit got = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (vec_valid) begin got = 1; break; end
        end
        chk(got && vec_addr == exp, tag, got ? int'(vec_addr) : 'hDEAD, int'(exp));
        if (got) begin
            ack = 1; @(negedge clk); ack = 0;
        end
    endtask

    task automatic expect_none(input int n, input string tag);
        bit seen = 0;
        int a = 0;
        repeat (n) begin
            @(negedge clk);
            if (vec_valid) begin seen = 1; a = int'(vec_addr); end
        end
        chk(!seen, tag, a, 0);
    endtask

    task automatic pulse_evt(input int which);
        case (which)
            0: nmi_evt = 1;
            1: cop_evt = 1;
            2: adc_evt = 1;
            default: tmr_evt = 1;
        endcase
        @(negedge clk);
        nmi_evt = 0; cop_evt = 0; adc_evt = 0; tmr_evt = 0;
    endtask

    task automatic t_reset;
        tick(3);
        chk(vec_valid == 0, "R1 no vector in reset", vec_valid, 0);
        chk(cpu_hold == 0, "R1 no hold in reset", cpu_hold, 0);
        rst_n = 1;
        expect_vec(16'hFFFC, "R1 first vector is reset");
        expect_none(8, "R1 quiet after reset ack");
    endtask

    task automatic t_vectors;
        pulse_evt(0); expect_vec(16'hFFFA, "R3 nmi vector");
        pulse_evt(1); expect_vec(16'hFFF0, "R3 coprocessor vector");
        pulse_evt(2); expect_vec(16'hFFF2, "R3 converter vector");
        pulse_evt(3); expect_vec(16'hFFF6, "R3 timer vector");
    endtask

    task automatic t_pins;
        pin_in[3] = 0;
        expect_none(10, "R4 default enables block pin");
        pin_in[3] = 1; tick(6);
        pin_en_n_we = 1; pin_en_n_wdata = 8'hF7; @(negedge clk); pin_en_n_we = 0;
        pin_in[3] = 0;
        expect_vec(16'hFFF8, "R4 enabled pin falling edge");
        pin_in[3] = 1;
        expect_none(10, "R4 rising edge ignored");
        pin_in[2] = 0;
        expect_none(10, "R4 disabled neighbour ignored");
        pin_in[2] = 1; tick(6);
    endtask

    task automatic t_ext;
        ext_irq_mode = 0; ext_pin = 1;
        expect_none(10, "R5 rise ignored when not in irq mode");
        ext_pin = 0; tick(6);
        ext_irq_mode = 1; ext_pin = 1;
        expect_vec(16'hFFFE, "R5 rising edge in irq mode");
        ext_pin = 0;
        expect_none(10, "R5 falling edge ignored");
    endtask

    task automatic t_mask;
        irq_mask = 1;
        pulse_evt(1);
        expect_none(8, "R6 masked coprocessor held");
        pulse_evt(0);
        expect_vec(16'hFFFA, "R6 nmi ignores mask");
        expect_none(6, "R6 masked source still held");
        irq_mask = 0;
        expect_vec(16'hFFF0, "R6 released after unmask");
    endtask

    task automatic t_prio;
        nmi_evt = 1; cop_evt = 1; adc_evt = 1; tmr_evt = 1;
        @(negedge clk);
        nmi_evt = 0; cop_evt = 0; adc_evt = 0; tmr_evt = 0;
        expect_vec(16'hFFFA, "R2 nmi first");
        expect_vec(16'hFFF0, "R2 coprocessor second");
        expect_vec(16'hFFF2, "R2 converter third");
        expect_vec(16'hFFF6, "R2 timer fourth");
        irq_mask = 1;
        pin_in[3] = 0; ext_pin = 1; tick(8);
        pulse_evt(3);
        irq_mask = 0;
        expect_vec(16'hFFF6, "R2 timer before pins");
        expect_vec(16'hFFF8, "R2 pins before external");
        expect_vec(16'hFFFE, "R2 external last");
        pin_in[3] = 1; ext_pin = 0; tick(6);
    endtask

    task automatic t_stable;
        bit held = 1;
        pulse_evt(2);
        for (int i = 0; i < 16 && !vec_valid; i++) @(negedge clk);
        pulse_evt(0);
        repeat (4) begin
            @(negedge clk);
            if (!vec_valid || vec_addr != 16'hFFF2) held = 0;
        end
        chk(held, "R7 vector held despite nmi", int'(vec_addr), 'hFFF2);
        ack = 1; @(negedge clk); ack = 0;
        chk(vec_valid == 0, "R7 vector dropped after ack", vec_valid, 0);
        expect_vec(16'hFFFA, "R7 other pending kept");
    endtask

    task automatic t_standby;
        stby_req = 1; @(negedge clk); stby_req = 0;
        chk(cpu_hold == 1, "R8 standby holds", cpu_hold, 1);
        irq_mask = 1;
        tick(3);
        chk(cpu_hold == 1, "R8 hold persists idle", cpu_hold, 1);
        tmr_evt = 1; @(negedge clk); tmr_evt = 0;
        chk(wake == 1, "R8 masked timer wakes", wake, 1);
        @(negedge clk);
        chk(cpu_hold == 0, "R8 hold released", cpu_hold, 1'b0);
        irq_mask = 0;
        expect_vec(16'hFFF6, "R8 timer served after wake");
        // request during grant is dropped
        pulse_evt(1);
        for (int i = 0; i < 16 && !vec_valid; i++) @(negedge clk);
        stby_req = 1; @(negedge clk); stby_req = 0;
        ack = 1; @(negedge clk); ack = 0;
        tick(3);
        chk(cpu_hold == 0, "R10 standby request in grant dropped", cpu_hold, 0);
    endtask

    task automatic t_sleep;
        bit woke = 0;
        ext_irq_mode = 1;
        sleep_req = 1; stby_req = 1; @(negedge clk); sleep_req = 0; stby_req = 0;
        chk(cpu_hold == 1, "R10 sleep entered", cpu_hold, 1);
        pulse_evt(0);
        pulse_evt(2);
        tick(4);
        chk(cpu_hold == 1, "R9 nmi does not wake sleep", cpu_hold, 1);
        expect_none(2, "R9 no vector in sleep");
        ext_pin = 1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (wake) begin woke = 1; break; end
        end
        chk(woke, "R9 external wakes sleep", woke, 1);
        @(negedge clk);
        chk(cpu_hold == 0, "R9 hold released", cpu_hold, 0);
        expect_vec(16'hFFFA, "R9 nmi served first");
        expect_vec(16'hFFF2, "R9 converter next");
        expect_vec(16'hFFFE, "R9 external last");
        ext_pin = 0; tick(6);
    endtask

    initial begin
        t_reset();
        t_vectors();
        t_pins();
        t_ext();
        t_mask();
        t_prio();
        t_stable();
        t_standby();
        t_sleep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule